// File: doc/BRIEF.md
# Integer Add/Subtract/Compare Unit

This block is the arithmetic slice of a simple RISC execute stage. It takes two operand words and a three-bit operation code. In the same cycle it returns a result word and a signed-overflow flag. It covers six operations: add and subtract, each in a trapping form and a non-trapping form, plus signed and unsigned less-than tests.

A single ripple of addition serves every operation. For subtraction and for both comparisons, the unit inverts the second operand and feeds in a carry of one, so it computes A plus the two's complement of B. The less-than answers come from the difference: the unsigned answer is the inverted carry-out, and the signed answer is the sign bit of the difference corrected by overflow.

The unit has no internal state. Its outputs are a pure function of its present inputs.

Top module: `int_arith_unit`

## Requirements
- R1: With op_sel 000 or 001, result equals (opnd_a + opnd_b) modulo 2^WIDTH. The sign bit gets no special handling.
- R2: With op_sel 010 or 011, result equals (opnd_a - opnd_b) modulo 2^WIDTH.
- R3: With op_sel 000 (add) or 010 (subtract), ovf is 1 exactly when the true signed sum or difference falls outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R4: For every op_sel other than 000 and 010, ovf is 0. This holds even when the same operands would overflow under 000 or 010.
- R5: With op_sel 100, result is 1 when opnd_a is less than opnd_b as two's complement numbers, and 0 otherwise. All bits above bit 0 are 0.
- R6: With op_sel 101, result is 1 when opnd_a is less than opnd_b as unsigned numbers, and 0 otherwise. All bits above bit 0 are 0.
- R7: The unused codes 110 and 111 give result 0 and ovf 0.
- R8: Adding 1 to the all-ones word with op_sel 000 gives result 0 and ovf 0; the carry-out is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code; see R1 to R7 |
| result | output | WIDTH | Sum, difference, or 0/1 comparison answer |
| ovf | output | 1 | Signed overflow; only 000 and 010 can assert it |

## Verification
The bench builds the unit with its default WIDTH of 32. It computes reference values in 64-bit signed arithmetic, so every true sum and difference is exact. This lets the bench reach the sign-boundary cases around 0x7FFFFFFF and 0x80000000 directly. It reaches the carry-out wrap of the all-ones word and the signed-versus-unsigned disagreement of the comparisons at bit 31. The same operands are repeated under the trapping and non-trapping codes, so a leak of overflow into the non-trapping forms becomes visible. A pseudo-random sweep over all eight codes follows.

// File: rtl/int_arith_pkg.sv
package int_arith_pkg;

    localparam int unsigned OP_W = 3;

    localparam logic [OP_W-1:0] OP_ADD  = 3'b000;
    localparam logic [OP_W-1:0] OP_ADDU = 3'b001;
    localparam logic [OP_W-1:0] OP_SUB  = 3'b010;
    localparam logic [OP_W-1:0] OP_SUBU = 3'b011;
    localparam logic [OP_W-1:0] OP_SLT  = 3'b100;
    localparam logic [OP_W-1:0] OP_SLTU = 3'b101;

    // Control bundle produced by the decoder
    typedef struct packed {
        logic invert_b;   // complement B and inject carry of one
        logic trap_ovf;   // overflow may reach the output
        logic pick_sum;   // result comes from the adder
        logic pick_lt;    // result is the comparison bit
        logic lt_signed;  // comparison is two's complement
    } arith_ctl_t;

endpackage

// File: rtl/arith_op_decode.sv
module arith_op_decode
    import int_arith_pkg::*;
(
    input  logic [OP_W-1:0] op_sel,
    output arith_ctl_t      ctl
);

    arith_ctl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        unique case (op_sel)
            OP_ADD:  begin ctl_d.pick_sum = 1'b1; ctl_d.trap_ovf = 1'b1; end
            OP_ADDU: begin ctl_d.pick_sum = 1'b1; end
            OP_SUB:  begin ctl_d.pick_sum = 1'b1; ctl_d.trap_ovf = 1'b1;
                           ctl_d.invert_b = 1'b1; end
            OP_SUBU: begin ctl_d.pick_sum = 1'b1; ctl_d.invert_b = 1'b1; end
            OP_SLT:  begin ctl_d.pick_lt = 1'b1; ctl_d.invert_b = 1'b1;
                           ctl_d.lt_signed = 1'b1; end
            OP_SLTU: begin ctl_d.pick_lt = 1'b1; ctl_d.invert_b = 1'b1; end
            default: ctl_d = '0;
        endcase
    end

    assign ctl = ctl_d;

    // R7: reserved codes drive nothing
    always_comb begin
        if (op_sel[2:1] == 2'b11)
            p_reserved_idle_r7: assert (ctl == '0)
                else $error("reserved code produced control");
    end

endmodule

// File: rtl/arith_addsub_core.sv
module arith_addsub_core #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             invert_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             sgn_ovf
);

    localparam int unsigned EXT_W = WIDTH + 1;
    localparam int unsigned MSB   = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             carry;
        logic             ovf;
    } core_out_t;

    core_out_t        core_d;
    logic [WIDTH-1:0] b_eff;
    logic [EXT_W-1:0] wide;

    always_comb begin
        b_eff = invert_b ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, invert_b};
        core_d.sum   = wide[WIDTH-1:0];
        core_d.carry = wide[WIDTH];
        // same-sign inputs with a sign-flipped result
        core_d.ovf   = (a[MSB] == b_eff[MSB]) && (core_d.sum[MSB] != a[MSB]);
    end

    assign sum       = core_d.sum;
    assign carry_out = core_d.carry;
    assign sgn_ovf   = core_d.ovf;

    // R8: all-ones plus one wraps to zero with a carry and no overflow
    always_comb begin
        if (!invert_b && (a == {WIDTH{1'b1}}) && (b == {{(WIDTH-1){1'b0}}, 1'b1}))
            p_minus_one_wrap_r8: assert (sum == '0 && carry_out && !sgn_ovf)
                else $error("minus one plus one did not wrap");
    end

    // R2: x - x is zero with a carry-out
    always_comb begin
        if (invert_b && (a == b))
            p_self_sub_zero_r2: assert (sum == '0 && carry_out)
                else $error("self subtraction not zero");
    end

endmodule

// File: rtl/arith_lt_derive.sv
module arith_lt_derive (
    input  logic sum_msb,
    input  logic carry_out,
    input  logic sgn_ovf,
    input  logic lt_signed,
    output logic lt
);

    logic lt_s_d;
    logic lt_u_d;

    always_comb begin
        lt_s_d = sum_msb ^ sgn_ovf;
        lt_u_d = ~carry_out;
        lt     = lt_signed ? lt_s_d : lt_u_d;
    end

endmodule

// File: rtl/int_arith_unit.sv
module int_arith_unit
    import int_arith_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [OP_W-1:0]  op_sel,
    output logic [WIDTH-1:0] result,
    output logic             ovf
);

    localparam int unsigned PAD_W = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             ovf;
    } unit_out_t;

    arith_ctl_t       ctl;
    logic [WIDTH-1:0] sum;
    logic             carry_out;
    logic             sgn_ovf;
    logic             lt;
    unit_out_t        out_d;

    arith_op_decode u_decode (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    arith_addsub_core #(.WIDTH(WIDTH)) u_core (
        .a         (opnd_a),
        .b         (opnd_b),
        .invert_b  (ctl.invert_b),
        .sum       (sum),
        .carry_out (carry_out),
        .sgn_ovf   (sgn_ovf)
    );

    arith_lt_derive u_lt (
        .sum_msb   (sum[WIDTH-1]),
        .carry_out (carry_out),
        .sgn_ovf   (sgn_ovf),
        .lt_signed (ctl.lt_signed),
        .lt        (lt)
    );

    always_comb begin
        out_d = '0;
        if (ctl.pick_sum)
            out_d.res = sum;
        else if (ctl.pick_lt)
            out_d.res = {{PAD_W{1'b0}}, lt};
        out_d.ovf = ctl.trap_ovf & sgn_ovf;
    end

    assign result = out_d.res;
    assign ovf    = out_d.ovf;

    // R4: overflow confined to the trapping add and subtract
    always_comb begin
        if (op_sel != OP_ADD && op_sel != OP_SUB)
            p_no_overflow_r4: assert (!ovf)
                else $error("overflow outside trapping ops");
    end

    // R5 / R6: comparison answers occupy bit 0 only
    always_comb begin
        if (op_sel == OP_SLT || op_sel == OP_SLTU)
            p_lt_one_bit_r5: assert (result[WIDTH-1:1] == '0)
                else $error("comparison result wider than one bit");
    end

    // R6: equal operands are never unsigned-less
    always_comb begin
        if (op_sel == OP_SLTU && opnd_a == opnd_b)
            p_ltu_equal_r6: assert (result == '0)
                else $error("equal operands compared less");
    end

    // R7: reserved codes give a quiet zero
    always_comb begin
        if (op_sel[2:1] == 2'b11)
            p_reserved_zero_r7: assert (result == '0 && !ovf)
                else $error("reserved code gave nonzero output");
    end

endmodule

// File: tb/tb_int_arith_unit.sv
module tb_int_arith_unit;

    localparam int unsigned WIDTH = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] opnd_a = '0;
    logic [WIDTH-1:0] opnd_b = '0;
    logic [2:0]       op_sel = 3'b000;
    logic [WIDTH-1:0] result;
    logic             ovf;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [2:0]  op;
        logic [31:0] exp_res;
        logic        exp_ovf;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    int_arith_unit #(.WIDTH(WIDTH)) dut (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .op_sel (op_sel),
        .result (result),
        .ovf    (ovf)
    );

    function automatic void ref_model(input logic [31:0] a, input logic [31:0] b,
                                      input logic [2:0] op,
                                      output logic [31:0] r, output logic o);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'({32'b0, a});
        longint ub = longint'({32'b0, b});
        longint full = 0;
        r = '0;
        o = 1'b0;
        case (op)
            3'd0, 3'd1: begin
                full = sa + sb;
                r = 32'(full);
                o = (op == 3'd0) && (full > 64'sd2147483647 || full < -64'sd2147483648);
            end
            3'd2, 3'd3: begin
                full = sa - sb;
                r = 32'(full);
                o = (op == 3'd2) && (full > 64'sd2147483647 || full < -64'sd2147483648);
            end
            3'd4: r = (sa < sb) ? 32'd1 : 32'd0;
            3'd5: r = (ua < ub) ? 32'd1 : 32'd0;
            default: begin r = '0; o = 1'b0; end
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0:    return "R1 R3";
            3'd1:    return "R1 R4";
            3'd2:    return "R2 R3";
            3'd3:    return "R2 R4";
            3'd4:    return "R5";
            3'd5:    return "R6";
            default: return "R7";
        endcase
    endfunction

    // driver: applies a vector after a rising edge and queues its expectation
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] op, input string tag);
        sb_item_t it;
        @(posedge clk);
        #1;
        opnd_a = a;
        opnd_b = b;
        op_sel = op;
        it.a = a;
        it.b = b;
        it.op = op;
        it.tag = tag;
        ref_model(a, b, op, it.exp_res, it.exp_ovf);
        sb_q.push_back(it);
    endtask

    // monitor: compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_vec++;
                if (result !== it.exp_res || ovf !== it.exp_ovf) begin
                    n_fail++;
                    $display("FAIL %s op=%0d a=%h b=%h: got res=%h ovf=%b, expected res=%h ovf=%b",
                             it.tag, it.op, it.a, it.b, result, ovf, it.exp_res, it.exp_ovf);
                end
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        int cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fail++;
                $display("FAIL watchdog: got %0d cycles, expected under 20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] seed;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // state after reset: zero inputs, add
        @(negedge clk);
        n_vec++;
        if (result !== 32'd0 || ovf !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got res=%h ovf=%b, expected res=0 ovf=0", result, ovf);
        end

        // R1 plain sums and wrap
        apply(32'd5, 32'd7, 3'd0, "R1");
        apply(32'hFFFF_FFFF, 32'd2, 3'd1, "R1");
        apply(32'h1234_5678, 32'h8765_4321, 3'd0, "R1");
        // R8 minus one plus one
        apply(32'hFFFF_FFFF, 32'd1, 3'd0, "R8");
        // R3 add overflow at both ends
        apply(32'h7FFF_FFFF, 32'd1, 3'd0, "R3");
        apply(32'h8000_0000, 32'hFFFF_FFFF, 3'd0, "R3");
        apply(32'h8000_0000, 32'h8000_0000, 3'd0, "R3");
        // R4 same operands, non-trapping add
        apply(32'h7FFF_FFFF, 32'd1, 3'd1, "R4");
        apply(32'h8000_0000, 32'h8000_0000, 3'd1, "R4");
        // R2 differences and R3 subtract overflow
        apply(32'd5, 32'd3, 3'd2, "R2");
        apply(32'd3, 32'd5, 3'd2, "R2");
        apply(32'h8000_0000, 32'd1, 3'd2, "R3");
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'd2, "R3");
        apply(32'd0, 32'h8000_0000, 3'd2, "R3");
        apply(32'hFFFF_FFFF, 32'h8000_0000, 3'd2, "R3");
        // R4 non-trapping subtract
        apply(32'h8000_0000, 32'd1, 3'd3, "R4");
        apply(32'd0, 32'h8000_0000, 3'd3, "R4");
        // R5 signed less-than
        apply(32'hFFFF_FFFF, 32'd1, 3'd4, "R5");
        apply(32'd1, 32'hFFFF_FFFF, 3'd4, "R5");
        apply(32'd9, 32'd9, 3'd4, "R5");
        apply(32'h8000_0000, 32'h7FFF_FFFF, 3'd4, "R5");
        apply(32'h7FFF_FFFF, 32'h8000_0000, 3'd4, "R5");
        // R6 unsigned less-than
        apply(32'hFFFF_FFFF, 32'd1, 3'd5, "R6");
        apply(32'd1, 32'hFFFF_FFFF, 3'd5, "R6");
        apply(32'hABCD_0000, 32'hABCD_0000, 3'd5, "R6");
        apply(32'd0, 32'd1, 3'd5, "R6");
        apply(32'h8000_0000, 32'h7FFF_FFFF, 3'd5, "R6");
        // R7 reserved codes with overflowing operands
        apply(32'h7FFF_FFFF, 32'd1, 3'd6, "R7");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, "R7");

        // pseudo-random sweep
        seed = 32'h2545_F491;
        for (int i = 0; i < 240; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            ra = seed;
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            rb = (i % 5 == 0) ? ra : seed;
            apply(ra, rb, 3'(i % 8), op_tag(3'(i % 8)));
        end

        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule